// File: doc/BRIEF.md
# Zero-Suppressed Charge Readout Sequencer

After a trigger accept, this block collects the 8-bit charge samples of one 64-channel module. Four converters each scan 16 inputs. Every channel is compared with its own programmable threshold. A channel whose sample is larger than its threshold is sent over an 8-bit parallel link as two bytes: the channel address first, then the sample. The link byte bus has a valid strobe and carries one byte per clock.

Samples may arrive from the four converters in the same cycle. Such hits are queued and sent in converter order, so a full burst is never lost. Once every converter has delivered its 16 samples and the queue is empty, a trailer byte of all ones closes the record and the busy flag drops. An accept that arrives while a record is in progress is not acted on; it only increments a rejected-accept counter.

Top module: `zs_readout_seq`

## Requirements
- R1: After reset, `link_valid_o` is 0, `busy_o` is 0, `rej_cnt_o` is 0 and every threshold is 0.
- R2: An `accept_i` pulse while idle raises `busy_o` on the next clock. While idle with no accept, `link_valid_o` stays low.
- R3: A sample is sent only when it is strictly greater than the threshold of its channel. A sample equal to its threshold is dropped, so a threshold of 0xFF drops the channel in every case.
- R4: A surviving channel is sent as an address byte, then its data byte in the very next cycle. The address byte has bit 7 clear and holds converter_index*16 + sample_index, where sample_index counts the samples that converter has delivered since the accept.
- R5: Hits from converters that deliver in the same cycle are sent in converter order 0 to 3. A full four-converter burst is queued without loss.
- R6: Once all four converters have delivered 16 samples and all queued pairs have been sent, one byte 0xFF is sent with `link_valid_o` high. `busy_o` is 0 in that same cycle.
- R7: Each cycle in which `accept_i` is high while `busy_o` is high increments `rej_cnt_o` by one and leaves the byte stream unchanged.
- R8: Writing `thr_wdata_i` to channel `thr_addr_i` with `thr_we_i` high sets that channel's threshold for all later scans.
- R9: Sample strobes that arrive while `busy_o` is low are ignored: they produce no link traffic and do not advance any converter's sample index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| accept_i | input | 1 | Trigger accept pulse |
| smp_valid_i | input | 4 | Per-converter sample strobe |
| smp_data_i | input | 32 | Per-converter sample; converter c uses bits [8c+7:8c] |
| thr_we_i | input | 1 | Threshold write enable |
| thr_addr_i | input | 6 | Threshold channel index |
| thr_wdata_i | input | 8 | Threshold value |
| link_data_o | output | 8 | Link byte |
| link_valid_o | output | 1 | Link byte valid |
| busy_o | output | 1 | Record in progress |
| rej_cnt_o | output | 8 | Count of accepts rejected while busy (wraps) |

## Verification
The assertions check the byte framing on every cycle:
- an address byte has bit 7 clear and is always followed by a data byte;
- the fall of busy coincides with the 0xFF trailer;
- the link is silent while idle;
- an accept while idle starts a record;
- the rejected counter moves exactly when an accept meets busy;
- the queue is never offered more hits than it has free entries.

Suppression at equality, channel addressing, the converter order inside a burst, and the effect of threshold writes depend on the data values. Only the bench's scenarios can show these, by comparing the captured byte stream with a stream built from the requirements.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_RUN,
    TX_DATA
  } tx_state_e;
endpackage

// File: rtl/zs_thr_table.sv
module zs_thr_table #(
  parameter int unsigned N_CH   = 64,
  parameter int unsigned N_RD   = 4,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned SMP_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        waddr_i,
  input  logic [SMP_W-1:0]         wdata_i,
  input  logic [N_RD*ADDR_W-1:0]   raddr_i,
  output logic [N_RD*SMP_W-1:0]    rdata_o
);
  logic [SMP_W-1:0] thr_q [N_CH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_CH); i++) thr_q[i] <= '0;
    end else if (we_i) begin
      thr_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rdata_o[r*SMP_W +: SMP_W] = thr_q[raddr_i[r*ADDR_W +: ADDR_W]];
  end
endmodule

// File: rtl/zs_conv_lane.sv
module zs_conv_lane #(
  parameter int unsigned CH_PER_CONV = 16,
  parameter int unsigned SMP_W       = 8,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned LANE        = 0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     run_i,
  input  logic                     smp_valid_i,
  input  logic [SMP_W-1:0]         smp_data_i,
  output logic [ADDR_W-1:0]        thr_raddr_o,
  input  logic [SMP_W-1:0]         thr_rdata_i,
  output logic                     push_o,
  output logic [ADDR_W+SMP_W-1:0]  entry_o,
  output logic                     done_o
);
  localparam int unsigned CH_W = $clog2(CH_PER_CONV);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(LANE * CH_PER_CONV);

  logic [CH_W:0] idx_q;
  logic          take;

  assign done_o = (idx_q == (CH_W+1)'(CH_PER_CONV));
  assign take   = run_i && smp_valid_i && !done_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (take)    idx_q <= idx_q + 1'b1;
  end

  assign thr_raddr_o = BASE + ADDR_W'(idx_q[CH_W-1:0]);
  // strict compare: equality suppresses, so all-ones threshold kills the channel
  assign push_o      = take && (smp_data_i > thr_rdata_i);
  assign entry_o     = {thr_raddr_o, smp_data_i};
endmodule

// File: rtl/zs_hit_fifo.sv
// Multi-write FIFO, lane order preserved within a cycle. DEPTH must be a power of two.
module zs_hit_fifo #(
  parameter int unsigned N_WR  = 4,
  parameter int unsigned ENT_W = 14,
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [N_WR-1:0]          push_i,
  input  logic [N_WR*ENT_W-1:0]    wdata_i,
  input  logic                     pop_i,
  output logic [ENT_W-1:0]         rdata_o,
  output logic                     empty_o,
  output logic [$clog2(DEPTH):0]   cnt_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   cnt_q;
  logic [PTR_W-1:0] slot [N_WR];
  logic [PTR_W:0]   n_push;

  always_comb begin
    n_push = '0;
    for (int i = 0; i < int'(N_WR); i++) begin
      slot[i] = wr_q + n_push[PTR_W-1:0];
      n_push  = n_push + (PTR_W+1)'(push_i[i]);
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(N_WR); i++) begin
      if (push_i[i]) mem_q[slot[i]] <= wdata_i[i*ENT_W +: ENT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_q + n_push[PTR_W-1:0];
      rd_q  <= rd_q + PTR_W'(pop_i);
      cnt_q <= cnt_q + n_push - (PTR_W+1)'(pop_i);
    end
  end

  assign rdata_o = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/zs_readout_seq.sv
module zs_readout_seq
  import zs_pkg::*;
#(
  parameter int unsigned N_CONV      = 4,
  parameter int unsigned CH_PER_CONV = 16,
  parameter int unsigned SMP_W       = 8,
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned REJ_W       = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  accept_i,
  input  logic [N_CONV-1:0]                     smp_valid_i,
  input  logic [N_CONV*SMP_W-1:0]               smp_data_i,
  input  logic                                  thr_we_i,
  input  logic [$clog2(N_CONV*CH_PER_CONV)-1:0] thr_addr_i,
  input  logic [SMP_W-1:0]                      thr_wdata_i,
  output logic [SMP_W-1:0]                      link_data_o,
  output logic                                  link_valid_o,
  output logic                                  busy_o,
  output logic [REJ_W-1:0]                      rej_cnt_o
);
  localparam int unsigned N_CH   = N_CONV * CH_PER_CONV;
  localparam int unsigned ADDR_W = $clog2(N_CH);
  localparam int unsigned ENT_W  = ADDR_W + SMP_W;
  localparam int unsigned PTR_W  = $clog2(FIFO_DEPTH);

  tx_state_e              st_q;
  logic                   start, run, pop, all_done, fifo_empty;
  logic                   tx_addr_q;
  logic [SMP_W-1:0]       hold_q;
  logic [REJ_W-1:0]       rej_q;
  logic [N_CONV-1:0]      lane_push, lane_done;
  logic [N_CONV*ENT_W-1:0]  lane_ent;
  logic [N_CONV*ADDR_W-1:0] thr_raddr;
  logic [N_CONV*SMP_W-1:0]  thr_rdata;
  logic [ENT_W-1:0]       head;
  logic [PTR_W:0]         fifo_cnt;

  assign run      = (st_q != TX_IDLE);
  assign start    = accept_i && !run;
  assign all_done = &lane_done;
  assign pop      = (st_q == TX_RUN) && !fifo_empty;

  zs_thr_table #(
    .N_CH  (N_CH),
    .N_RD  (N_CONV),
    .ADDR_W(ADDR_W),
    .SMP_W (SMP_W)
  ) i_thr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (thr_we_i),
    .waddr_i(thr_addr_i),
    .wdata_i(thr_wdata_i),
    .raddr_i(thr_raddr),
    .rdata_o(thr_rdata)
  );

  for (genvar g = 0; g < N_CONV; g++) begin : g_lane
    zs_conv_lane #(
      .CH_PER_CONV(CH_PER_CONV),
      .SMP_W      (SMP_W),
      .ADDR_W     (ADDR_W),
      .LANE       (g)
    ) i_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .start_i    (start),
      .run_i      (run),
      .smp_valid_i(smp_valid_i[g]),
      .smp_data_i (smp_data_i[g*SMP_W +: SMP_W]),
      .thr_raddr_o(thr_raddr[g*ADDR_W +: ADDR_W]),
      .thr_rdata_i(thr_rdata[g*SMP_W +: SMP_W]),
      .push_o     (lane_push[g]),
      .entry_o    (lane_ent[g*ENT_W +: ENT_W]),
      .done_o     (lane_done[g])
    );
  end

  zs_hit_fifo #(
    .N_WR (N_CONV),
    .ENT_W(ENT_W),
    .DEPTH(FIFO_DEPTH)
  ) i_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .push_i (lane_push),
    .wdata_i(lane_ent),
    .pop_i  (pop),
    .rdata_o(head),
    .empty_o(fifo_empty),
    .cnt_o  (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= TX_IDLE;
      link_data_o  <= '0;
      link_valid_o <= 1'b0;
      hold_q       <= '0;
      tx_addr_q    <= 1'b0;
    end else begin
      case (st_q)
        TX_IDLE: begin
          link_valid_o <= 1'b0;
          tx_addr_q    <= 1'b0;
          if (accept_i) st_q <= TX_RUN;
        end
        TX_RUN: begin
          if (!fifo_empty) begin
            link_data_o  <= SMP_W'(head[ENT_W-1:SMP_W]);
            link_valid_o <= 1'b1;
            hold_q       <= head[SMP_W-1:0];
            tx_addr_q    <= 1'b1;
            st_q         <= TX_DATA;
          end else if (all_done) begin
            // trailer; busy drops on the same edge
            link_data_o  <= {SMP_W{1'b1}};
            link_valid_o <= 1'b1;
            tx_addr_q    <= 1'b0;
            st_q         <= TX_IDLE;
          end else begin
            link_valid_o <= 1'b0;
            tx_addr_q    <= 1'b0;
          end
        end
        TX_DATA: begin
          link_data_o  <= hold_q;
          link_valid_o <= 1'b1;
          tx_addr_q    <= 1'b0;
          st_q         <= TX_RUN;
        end
        default: st_q <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rej_q <= '0;
    else if (accept_i && run) rej_q <= rej_q + 1'b1;
  end

  assign busy_o    = run;
  assign rej_cnt_o = rej_q;
endmodule

// File: rtl/zs_readout_seq_chk.sv
module zs_readout_seq_chk #(
  parameter int unsigned N_CONV     = 4,
  parameter int unsigned SMP_W      = 8,
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned REJ_W      = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          accept_i,
  input logic                          busy_o,
  input logic                          link_valid_o,
  input logic [SMP_W-1:0]              link_data_o,
  input logic [REJ_W-1:0]              rej_cnt_o,
  input logic                          tx_addr_q,
  input logic [N_CONV-1:0]             lane_push,
  input logic [$clog2(FIFO_DEPTH):0]   fifo_cnt
);
  assert_addr_msb_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && tx_addr_q |-> link_data_o[SMP_W-1] == 1'b0);

  assert_data_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && tx_addr_q |=> link_valid_o && !tx_addr_q);

  assert_trailer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> link_valid_o && link_data_o == {SMP_W{1'b1}});

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !accept_i |=> !link_valid_o);

  assert_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && accept_i |=> busy_o);

  assert_rej_inc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && accept_i |=> rej_cnt_o == REJ_W'($past(rej_cnt_o) + 1'b1));

  assert_rej_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && accept_i) |=> $stable(rej_cnt_o));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(lane_push) <= int'(FIFO_DEPTH) - int'(fifo_cnt));
endmodule

bind zs_readout_seq zs_readout_seq_chk #(
  .N_CONV    (N_CONV),
  .SMP_W     (SMP_W),
  .FIFO_DEPTH(FIFO_DEPTH),
  .REJ_W     (REJ_W)
) i_zs_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept_i    (accept_i),
  .busy_o      (busy_o),
  .link_valid_o(link_valid_o),
  .link_data_o (link_data_o),
  .rej_cnt_o   (rej_cnt_o),
  .tx_addr_q   (tx_addr_q),
  .lane_push   (lane_push),
  .fifo_cnt    (fifo_cnt)
);

// File: tb/test_zs_readout_seq.sv
`timescale 1ns/1ps
module test_zs_readout_seq;
  localparam int N_CONV = 4;
  localparam int CPC    = 16;
  localparam int N_CH   = N_CONV * CPC;
  localparam int GAP    = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        accept_i = 1'b0;
  logic [3:0]  smp_valid_i = '0;
  logic [31:0] smp_data_i = '0;
  logic        thr_we_i = 1'b0;
  logic [5:0]  thr_addr_i = '0;
  logic [7:0]  thr_wdata_i = '0;
  logic [7:0]  link_data_o;
  logic        link_valid_o;
  logic        busy_o;
  logic [7:0]  rej_cnt_o;

  int n_run = 0;
  int n_fail = 0;

  logic [7:0] smp [N_CH];
  logic [7:0] thr [N_CH];
  logic [7:0] cap_q [$];
  bit         cap_busy_q [$];
  logic [7:0] exp_q [$];

  always #4 clk_i = ~clk_i;

  zs_readout_seq i_zs_readout_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept_i),
    .smp_valid_i (smp_valid_i),
    .smp_data_i  (smp_data_i),
    .thr_we_i    (thr_we_i),
    .thr_addr_i  (thr_addr_i),
    .thr_wdata_i (thr_wdata_i),
    .link_data_o (link_data_o),
    .link_valid_o(link_valid_o),
    .busy_o      (busy_o),
    .rej_cnt_o   (rej_cnt_o)
  );

  always @(negedge clk_i) begin
    if (link_valid_o) begin
      cap_q.push_back(link_data_o);
      cap_busy_q.push_back(busy_o);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_thr(input int ch, input logic [7:0] v);
    @(negedge clk_i);
    thr_we_i = 1'b1; thr_addr_i = 6'(ch); thr_wdata_i = v;
    @(negedge clk_i);
    thr_we_i = 1'b0;
    thr[ch] = v;
  endtask

  // one scan; stagger spreads each slot's four samples over four cycles
  task automatic run_scan(input bit stagger, input int n_rej, input string req);
    exp_q.delete();
    for (int s = 0; s < CPC; s++)
      for (int c = 0; c < N_CONV; c++) begin
        int ch = c * CPC + s;
        if (smp[ch] > thr[ch]) begin
          exp_q.push_back(8'(ch));
          exp_q.push_back(smp[ch]);
        end
      end
    exp_q.push_back(8'hFF);
    cap_q.delete(); cap_busy_q.delete();
    @(negedge clk_i); accept_i = 1'b1;
    @(negedge clk_i); accept_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after accept", int'(busy_o), 1);
    for (int s = 0; s < CPC; s++) begin
      if (!stagger) begin
        smp_valid_i = 4'hF;
        for (int c = 0; c < N_CONV; c++) smp_data_i[c*8 +: 8] = smp[c*CPC+s];
        @(negedge clk_i);
      end else begin
        for (int c = 0; c < N_CONV; c++) begin
          smp_valid_i = 4'(1 << c);
          smp_data_i[c*8 +: 8] = smp[c*CPC+s];
          @(negedge clk_i);
        end
      end
      smp_valid_i = '0;
      if (s == 5) begin
        for (int k = 0; k < n_rej; k++) begin
          accept_i = 1'b1; @(negedge clk_i);
          accept_i = 1'b0; @(negedge clk_i);
        end
      end
      repeat (GAP) @(negedge clk_i);
    end
    while (busy_o) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
    chk(cap_q.size() == exp_q.size(), req, "byte count", cap_q.size(), exp_q.size());
    for (int k = 0; k < cap_q.size() && k < exp_q.size(); k++)
      chk(cap_q[k] == exp_q[k], req, $sformatf("byte %0d", k), int'(cap_q[k]), int'(exp_q[k]));
    if (cap_q.size() > 0) begin
      chk(cap_q[cap_q.size()-1] == 8'hFF, "R6", "trailer value", int'(cap_q[cap_q.size()-1]), 255);
      chk(cap_busy_q[cap_busy_q.size()-1] == 1'b0, "R6", "busy at trailer",
          int'(cap_busy_q[cap_busy_q.size()-1]), 0);
    end
  endtask

  task automatic t_reset_R1;
    chk(link_valid_o == 1'b0, "R1", "valid after reset", int'(link_valid_o), 0);
    chk(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    chk(rej_cnt_o == 8'd0, "R1", "rej after reset", int'(rej_cnt_o), 0);
  endtask

  task automatic t_idle_ignore_R9;
    cap_q.delete();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk_i);
      smp_valid_i = 4'hF; smp_data_i = 32'hC0C1C2C3;
    end
    @(negedge clk_i); smp_valid_i = '0;
    repeat (4) @(negedge clk_i);
    chk(cap_q.size() == 0, "R9", "idle link bytes", cap_q.size(), 0);
    chk(busy_o == 1'b0, "R2", "idle busy", int'(busy_o), 0);
  endtask

  task automatic t_pass_all_R5;
    for (int i = 0; i < N_CH; i++) smp[i] = (i % 5 == 0) ? 8'h00 : 8'(i * 7 + 3);
    run_scan(1'b0, 0, "R5");
  endtask

  task automatic t_thresholds_R8;
    for (int i = 0; i < N_CH; i++) begin
      logic [7:0] t = 8'(i * 4);
      write_thr(i, t);
      case (i % 3)
        0:       smp[i] = t;
        1:       smp[i] = t + 8'd1;
        default: smp[i] = t - 8'd1;
      endcase
    end
    write_thr(7, 8'hFF);  smp[7]  = 8'hFF;
    write_thr(63, 8'hFE); smp[63] = 8'hFF;
    run_scan(1'b1, 0, "R3");
  endtask

  task automatic t_reject_R7;
    logic [7:0] r0 = rej_cnt_o;
    for (int i = 0; i < N_CH; i++) smp[i] = 8'(255 - i);
    run_scan(1'b0, 3, "R7");
    chk(rej_cnt_o == r0 + 8'd3, "R7", "rejected count", int'(rej_cnt_o), int'(r0 + 8'd3));
  endtask

  task automatic t_all_suppressed_R6;
    for (int i = 0; i < N_CH; i++) write_thr(i, 8'hFF);
    for (int i = 0; i < N_CH; i++) smp[i] = 8'hFF;
    run_scan(1'b0, 0, "R6");
  endtask

  initial begin
    #(8ns * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N_CH; i++) begin thr[i] = 8'h00; smp[i] = 8'h00; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_R1();
    t_idle_ignore_R9();
    t_pass_all_R5();
    t_thresholds_R8();
    t_reject_R7();
    t_all_suppressed_R6();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule